// File: doc/BRIEF.md
# Laser Array Turn-On and Fault Sequencer

This block is the control logic of a twelve-lane laser transmitter. It decides, every clock cycle, which lanes may emit light. Light is allowed only when the host enables the array, does not disable it, holds the control reset inactive, and no fault has been latched. When the array is allowed to drive, the lanes are switched on one at a time in ascending order at a fixed spacing. This spacing comes after a long settling wait, or after the power-up initialisation interval. Removing permission switches every lane off at once.

Three fault indicators feed the block: over-current, temperature out of range, and corrupt calibration data. Any of them pulls the active-low fault output low and blanks the array. The fault stays latched until the control reset or the power-on reset clears it. A short glitch on the enable or disable input is filtered out: a disabling level counts only once it has been held for a qualification time. All asynchronous control inputs pass through two-flop synchronisers. Every delay is a parameter in clock cycles, so simulation can use small values.

Top module: `laser_seq_ctrl`

## Requirements
- R1: While `rst_ni` is low, all `chan_en_o` bits are 0 and `fault_no` is 1. Asserting `rst_ni` also clears a latched fault at once.
- R2: After `rst_ni` rises with permission present, lane i (bit i of `chan_en_o`) turns on at the INIT_CYC + i*STAGGER_CYC-th rising clock edge after release. INIT_CYC must be at least 4.
- R3: Lanes may drive only when `tx_en_i` is 1 and `tx_dis_i` is 0. `tx_en_i` low alone, or `tx_dis_i` high alone, keeps every lane off.
- R4: `ctl_rst_ni` low clears `chan_en_o` to 0 and clears the latched fault, both visible after the 3rd rising edge following the change.
- R5: A high level on any of `flt_ocur_i`, `flt_temp_i`, `flt_cal_i` (even for one cycle) drives `fault_no` low and clears `chan_en_o`, both after the 3rd rising edge.
- R6: Once `fault_no` is low, it stays low, with all lanes off, until `ctl_rst_ni` or `rst_ni` is asserted.
- R7: Switch-on waits the settle time. Lane 0 turns on SETTLE_CYC+3 edges after `ctl_rst_ni` rises, and SETTLE_CYC+4 edges after `tx_en_i` rises or `tx_dis_i` falls (the extra edge is the qualifier).
- R8: `chan_en_o` is always a thermometer code from bit 0. Lanes come on one per step, STAGGER_CYC edges apart, and at most one new lane per cycle.
- R9: A disabling level on `tx_en_i`/`tx_dis_i` held for fewer than QUAL_CYC cycles has no effect. One held QUAL_CYC cycles or longer clears `chan_en_o` at the QUAL_CYC+3-th edge after it appears.
- R10: Losing permission during the staggered turn-on aborts it at once. The next turn-on repeats the settle wait and restarts from lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Single synchronous clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| tx_en_i | input | 1 | Array enable, active high, asynchronous |
| tx_dis_i | input | 1 | Array disable, active high, asynchronous |
| ctl_rst_ni | input | 1 | Control reset, active low, asynchronous |
| flt_ocur_i | input | 1 | Drive over-current indicator |
| flt_temp_i | input | 1 | Temperature out-of-range indicator |
| flt_cal_i | input | 1 | Calibration data corruption indicator |
| chan_en_o | output | NCH | Per-lane emit enable, bit i is lane i |
| fault_no | output | 1 | Latched fault, active low |

## Verification
A wrong sequencer state shows up at `chan_en_o` as a lane that switches on early or late, out of order, or not at all. The bench measures the rising edge of every lane against arithmetic expectations, so it catches such an error on the first ramp it happens in. A qualifier counter that is off by one shows up in the sweep over glitch widths: either a pulse one cycle too short blanks the array, or one of exactly the threshold length is ignored. A fault latch that clears itself is caught within tens of cycles by the hold check, which reads `fault_no` and `chan_en_o` after the fault input has gone away.

// File: rtl/laser_seq_pkg.sv
package laser_seq_pkg;
  typedef enum logic [2:0] {
    ST_INIT,
    ST_OFF,
    ST_SETTLE,
    ST_RAMP,
    ST_ON
  } seq_state_e;

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/lsq_sync.sv
module lsq_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/lsq_qual.sv
// Permission drops only after the raw level has been low QUAL_CYC cycles; rises at once.
module lsq_qual #(
  parameter int QUAL_CYC = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic ok_o
);
  localparam int QW = $clog2(QUAL_CYC + 1);

  logic [QW-1:0] cnt_q;
  logic          ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_q  <= 1'b0;
      cnt_q <= '0;
    end else if (raw_i) begin
      ok_q  <= 1'b1;
      cnt_q <= '0;
    end else if (ok_q) begin
      if (cnt_q == QW'(QUAL_CYC - 1)) begin
        ok_q  <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign ok_o = ok_q;
endmodule

// File: rtl/lsq_fault.sv
module lsq_fault (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_ni,
  input  logic flt_i,
  output logic latched_o
);
  logic lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lat_q <= 1'b0;
    else if (!clr_ni) lat_q <= 1'b0;
    else if (flt_i)   lat_q <= 1'b1;
  end

  assign latched_o = lat_q;
endmodule

// File: rtl/lsq_ramp.sv
module lsq_ramp
  import laser_seq_pkg::*;
#(
  parameter int NCH         = 12,
  parameter int INIT_CYC    = 6000000,
  parameter int SETTLE_CYC  = 5500000,
  parameter int STAGGER_CYC = 460000
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           go_i,
  output logic [NCH-1:0] chan_en_o
);
  localparam int MAXC = max3(INIT_CYC, SETTLE_CYC, STAGGER_CYC);
  localparam int CW   = $clog2(MAXC + 1);

  seq_state_e     st_q;
  logic [CW-1:0]  cnt_q;
  logic [NCH-1:0] chan_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_INIT;
      cnt_q  <= '0;
      chan_q <= '0;
    end else if (st_q == ST_INIT) begin
      // power-up interval runs to completion, then ramps directly
      if (cnt_q == CW'(INIT_CYC - 1)) begin
        cnt_q <= '0;
        if (go_i) begin
          st_q   <= ST_RAMP;
          chan_q <= NCH'(1);
        end else begin
          st_q <= ST_OFF;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (!go_i) begin
      st_q   <= ST_OFF;
      cnt_q  <= '0;
      chan_q <= '0;
    end else begin
      unique case (st_q)
        ST_OFF: begin
          st_q  <= ST_SETTLE;
          cnt_q <= '0;
        end
        ST_SETTLE: begin
          if (cnt_q == CW'(SETTLE_CYC - 1)) begin
            cnt_q  <= '0;
            chan_q <= NCH'(1);
            st_q   <= ST_RAMP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_RAMP: begin
          if (cnt_q == CW'(STAGGER_CYC - 1)) begin
            cnt_q  <= '0;
            chan_q <= {chan_q[NCH-2:0], 1'b1};
            if (chan_q[NCH-2]) st_q <= ST_ON;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_ON:   st_q <= ST_ON;
        default: st_q <= ST_OFF;
      endcase
    end
  end

  assign chan_en_o = chan_q;
endmodule

// File: rtl/laser_seq_ctrl.sv
module laser_seq_ctrl #(
  parameter int NCH         = 12,
  parameter int INIT_CYC    = 6000000,
  parameter int SETTLE_CYC  = 5500000,
  parameter int STAGGER_CYC = 460000,
  parameter int QUAL_CYC    = 100000
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tx_en_i,
  input  logic           tx_dis_i,
  input  logic           ctl_rst_ni,
  input  logic           flt_ocur_i,
  input  logic           flt_temp_i,
  input  logic           flt_cal_i,
  output logic [NCH-1:0] chan_en_o,
  output logic           fault_no
);
  localparam int NIN = 6;

  logic [NIN-1:0] raw_in, syn;
  logic           en_s, dis_s, rst_s, flt_any_s;
  logic           perm_ok, flt_lat, go;

  assign raw_in = {flt_cal_i, flt_temp_i, flt_ocur_i, ctl_rst_ni, tx_dis_i, tx_en_i};

  lsq_sync #(.W(NIN)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (syn)
  );

  assign en_s      = syn[0];
  assign dis_s     = syn[1];
  assign rst_s     = syn[2];
  assign flt_any_s = |syn[5:3];

  lsq_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .raw_i (en_s & ~dis_s),
    .ok_o  (perm_ok)
  );

  lsq_fault u_fault (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_ni   (rst_s),
    .flt_i    (flt_any_s),
    .latched_o(flt_lat)
  );

  // raw fault term blanks lanes on the same edge the latch sets
  assign go = perm_ok & rst_s & ~flt_lat & ~flt_any_s;

  lsq_ramp #(
    .NCH        (NCH),
    .INIT_CYC   (INIT_CYC),
    .SETTLE_CYC (SETTLE_CYC),
    .STAGGER_CYC(STAGGER_CYC)
  ) u_ramp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (go),
    .chan_en_o(chan_en_o)
  );

  assign fault_no = ~flt_lat;
endmodule

// File: rtl/lsq_checker.sv
module lsq_checker #(
  parameter int NCH = 12
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [NCH-1:0] chan_en_i,
  input logic           fault_ni,
  input logic           rst_s_i,
  input logic           flt_s_i
);
  a_r5_fault_blanks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_ni |-> chan_en_i == '0);

  a_r5_fault_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_s_i && rst_s_i) |=> !fault_ni);

  a_r6_fault_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fault_ni && rst_s_i) |=> !fault_ni);

  a_r4_reset_kills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_s_i |=> chan_en_i == '0);

  a_r8_thermometer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_en_i & (chan_en_i + NCH'(1))) == '0);

  a_r8_one_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(chan_en_i & ~$past(chan_en_i)) <= 1);
endmodule

bind laser_seq_ctrl lsq_checker #(.NCH(NCH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .chan_en_i(chan_en_o),
  .fault_ni (fault_no),
  .rst_s_i  (rst_s),
  .flt_s_i  (flt_any_s)
);

// File: tb/sim_laser_seq_ctrl.sv
`timescale 1ns/1ps
module sim_laser_seq_ctrl;
  localparam int NCH = 4, INIT = 8, SETTLE = 10, STAG = 5, QUAL = 6;
  localparam int ALL = (1 << NCH) - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0, tx_en = 1'b1, tx_dis = 1'b0, crst_n = 1'b1;
  logic [2:0] flt = 3'b000;
  logic [NCH-1:0] chan;
  logic fault_no;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  laser_seq_ctrl #(.NCH(NCH), .INIT_CYC(INIT), .SETTLE_CYC(SETTLE),
                   .STAGGER_CYC(STAG), .QUAL_CYC(QUAL)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tx_en_i(tx_en), .tx_dis_i(tx_dis),
    .ctl_rst_ni(crst_n), .flt_ocur_i(flt[0]), .flt_temp_i(flt[1]),
    .flt_cal_i(flt[2]), .chan_en_o(chan), .fault_no(fault_no));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit cond(input int what, input int idx);
    case (what)
      0: return chan[idx];
      1: return chan == '0;
      2: return !fault_no;
      3: return fault_no;
      4: return chan == NCH'(ALL);
      default: return chan == NCH'(idx);
    endcase
  endfunction

  // count rising edges until the condition holds; -1 if never within lim
  task automatic meas(input int what, input int idx, input int lim, output int n);
    n = 0;
    do begin
      @(posedge clk); #1; n++;
    end while (!cond(what, idx) && n < lim);
    if (!cond(what, idx)) n = -1;
  endtask

  task automatic ramp(input int base, input int pre, input string req);
    int tot, n;
    tot = pre;
    for (int i = 0; i < NCH; i++) begin
      meas(0, i, 500, n);
      tot += n;
      check(tot == base + i * STAG, req, tot, base + i * STAG);
      check(int'(chan) == (1 << (i + 1)) - 1, "R8", int'(chan), (1 << (i + 1)) - 1);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n, first_off;
    repeat (3) @(negedge clk);
    check(chan == '0, "R1", int'(chan), 0);
    check(fault_no == 1'b1, "R1", int'(fault_no), 1);
    rst_ni = 1'b1;
    ramp(INIT, 0, "R2");

    // R9 / R3: sweep disabling pulse width on each control input
    for (int s = 0; s < 2; s++) begin
      for (int w = 1; w <= QUAL + 2; w++) begin
        @(negedge clk);
        if (s == 0) tx_en = 1'b0; else tx_dis = 1'b1;
        first_off = -1;
        for (int k = 1; k <= QUAL + 8; k++) begin
          @(posedge clk); #1;
          if (chan == '0 && first_off < 0) first_off = k;
          @(negedge clk);
          if (k == w) begin tx_en = 1'b1; tx_dis = 1'b0; end
        end
        if (w < QUAL) begin
          check(first_off == -1, "R9", first_off, -1);
          check(chan == NCH'(ALL), "R9", int'(chan), ALL);
        end else begin
          check(first_off == QUAL + 3, "R9", first_off, QUAL + 3);
          meas(4, 0, 300, n);
          check(n > 0, "R3", n, 1);
        end
      end
    end

    // R3: both disabling, then only enable low
    @(negedge clk); tx_en = 1'b0; tx_dis = 1'b1;
    repeat (QUAL + 6) @(negedge clk);
    check(chan == '0, "R3", int'(chan), 0);
    tx_dis = 1'b0;
    repeat (SETTLE + NCH * STAG + 10) @(negedge clk);
    check(chan == '0, "R3", int'(chan), 0);
    tx_en = 1'b1;
    ramp(SETTLE + 4, 0, "R7");

    // disable release timing
    @(negedge clk); tx_dis = 1'b1;
    meas(1, 0, 100, n);
    check(n == QUAL + 3, "R3", n, QUAL + 3);
    @(negedge clk); tx_dis = 1'b0;
    ramp(SETTLE + 4, 0, "R7");

    // R4: control reset
    @(negedge clk); crst_n = 1'b0;
    meas(1, 0, 100, n);
    check(n == 3, "R4", n, 3);
    repeat (4) @(negedge clk);
    crst_n = 1'b1;
    ramp(SETTLE + 3, 0, "R7");

    // R5 / R6: each fault source, one-cycle pulse
    for (int f = 0; f < 3; f++) begin
      @(negedge clk); flt[f] = 1'b1;
      @(negedge clk); flt[f] = 1'b0;
      meas(2, 0, 100, n);
      check(n + 1 == 3, "R5", n + 1, 3);
      check(chan == '0, "R5", int'(chan), 0);
      repeat (40) @(negedge clk);
      check(fault_no == 1'b0, "R6", int'(fault_no), 0);
      check(chan == '0, "R6", int'(chan), 0);
      @(negedge clk); crst_n = 1'b0;
      meas(3, 0, 100, n);
      check(n == 3, "R4", n, 3);
      @(negedge clk); crst_n = 1'b1;
      ramp(SETTLE + 3, 0, "R7");
    end

    // R10: abort mid-ramp
    @(negedge clk); tx_en = 1'b0;
    repeat (QUAL + 6) @(negedge clk);
    tx_en = 1'b1;
    meas(5, 3, 300, n);
    check(n > 0, "R10", n, 1);
    @(negedge clk); crst_n = 1'b0;
    @(negedge clk); crst_n = 1'b1;
    meas(1, 0, 100, n);
    check(n + 1 == 3, "R10", n + 1, 3);
    ramp(SETTLE + 4, n + 1, "R10");

    // R1 / R6: power-on reset clears a latched fault
    @(negedge clk); flt[1] = 1'b1;
    meas(2, 0, 100, n);
    check(n > 0, "R5", n, 1);
    @(negedge clk); flt[1] = 1'b0; rst_ni = 1'b0;
    #1;
    check(fault_no == 1'b1, "R1", int'(fault_no), 1);
    check(chan == '0, "R1", int'(chan), 0);
    @(negedge clk); rst_ni = 1'b1;
    ramp(INIT, 0, "R2");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule